// File: doc/BRIEF.md
# SECDED Hamming Codec

This block protects memory words with a Hamming code that corrects any single flipped bit and detects any pair of flipped bits. It has two independent registered paths. The encode path turns a data word into a code word for storage. The decode path takes a word read back from storage and returns the data, corrected where that is possible. Each decoded word also carries a flag saying whether a repair was made and a flag saying whether the word cannot be recovered.

Code bits are numbered by position starting at 1 and held at vector index position-1. Check bits sit at the power-of-two positions. Data bits fill the remaining positions in ascending order, with data bit 0 at position 3. An overall parity bit sits at the top index, CW-1. On decode, the recomputed check bits form a syndrome, and that syndrome is the position number of a single failing bit. The parity over the whole received word then decides which error case applies, and that includes an error in the overall bit itself. The data width is a parameter: the default is 4 data bits in an 8-bit word, and the width can grow to 64 data bits in a 72-bit word.

Top module: `secded_codec`

## Requirements
- R1: The code width is CW = DW + P + 1, where P is the smallest count with 2^P >= P + DW + 1. This gives 4->8 and 8->13 bits. Position n (counted from 1) lives at code index n-1. Check bit k sits at position 2^k. Data bit i sits at the i-th non-power-of-two position, so for DW=4 data bits 0..3 sit at positions 3, 5, 6 and 7. The overall parity bit sits at index CW-1.
- R2: Check bit k gives even parity over all positions whose number has bit k set. The overall bit gives the whole code word even parity. For DW=4, data 0x1 encodes to 0x87, 0xA to 0xD2, 0x5 to 0x2D, 0x8 to 0x4B and 0xF to 0xFF.
- R3: enc_code_o is registered. It updates on the clock edge at which enc_valid_i is high, and enc_valid_o is high for exactly the next cycle. While enc_valid_i is low, enc_code_o holds its value.
- R4: A received word with zero syndrome and even overall parity returns its data unchanged, with both flags low.
- R5: A single flip at any position from 1 to CW-1 gives a nonzero syndrome equal to that position, with odd overall parity. The bit is repaired and dec_corrected_o is high.
- R6: A flip of the overall bit alone gives zero syndrome and odd parity. The data is returned intact with dec_corrected_o high.
- R7: A nonzero syndrome with even overall parity raises dec_uncorrectable_o and leaves dec_corrected_o low. The data is passed through unrepaired, taken straight from the received data positions.
- R8: A syndrome larger than CW-1 with odd overall parity raises dec_uncorrectable_o, and the data is passed through unrepaired.
- R9: The decode outputs are registered. They update on the edge at which dec_valid_i is high, and dec_valid_o is high for exactly the next cycle. While dec_valid_i is low, data and flags hold their values.
- R10: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encode request |
| enc_data_i | input | DW | Data word to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | CW | Encoded word |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | CW | Received code word |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | DW | Decoded data |
| dec_corrected_o | output | 1 | A single error was repaired |
| dec_uncorrectable_o | output | 1 | The error cannot be repaired |

## Verification
The bench builds two instances. The first uses DW=4, where the eight-bit word uses every syndrome value. It is driven from hand-computed code words, covering clean, single, overall-bit and double-flip cases. The second uses DW=8, where the 13-bit word leaves syndromes 13 to 15 without a position. That makes the out-of-range case of R8 reachable through triple flips on check positions. The DW=8 instance also allows an exhaustive sweep of all 256 data words, with every single flip applied to each, plus a sampled set of double flips.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // smallest check-bit count covering DW data bits plus the no-error case
  function automatic int chk_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < (p + dw + 1)) p++;
    return p;
  endfunction

  // 1-based code position of data bit idx (skips power-of-two positions)
  function automatic int data_pos(input int idx);
    int pos;
    int cnt;
    pos = 0;
    cnt = -1;
    while (cnt < idx) begin
      pos++;
      if ((pos & (pos - 1)) != 0) cnt++;
    end
    return pos;
  endfunction

  function automatic bit covers(input int pos, input int k);
    return ((pos >> k) & 1) == 1;
  endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter  int DW = 4,
  localparam int P  = chk_bits(DW),
  localparam int HW = DW + P,
  localparam int CW = HW + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);

  logic [HW:1]  spread;
  logic [P-1:0] chk;

  for (genvar i = 0; i < DW; i++) begin : g_place
    localparam int POS = data_pos(i);
    assign spread[POS] = data_i[i];
  end

  for (genvar k = 0; k < P; k++) begin : g_zero
    assign spread[1 << k] = 1'b0;
  end

  always_comb begin
    chk = '0;
    for (int k = 0; k < P; k++) begin
      for (int pos = 1; pos <= HW; pos++) begin
        if (covers(pos, k)) chk[k] = chk[k] ^ spread[pos];
      end
    end
  end

  for (genvar pos = 1; pos <= HW; pos++) begin : g_out
    if ((pos & (pos - 1)) == 0) begin : g_chk
      assign code_o[pos-1] = chk[$clog2(pos)];
    end else begin : g_dat
      assign code_o[pos-1] = spread[pos];
    end
  end

  assign code_o[CW-1] = (^spread) ^ (^chk);

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
#(
  parameter  int DW = 4,
  localparam int P  = chk_bits(DW),
  localparam int HW = DW + P,
  localparam int CW = HW + 1
) (
  input  logic [CW-1:0] code_i,
  output logic [P-1:0]  syn_o,
  output logic          perr_o,
  output logic [DW-1:0] raw_o
);

  always_comb begin
    syn_o = '0;
    for (int k = 0; k < P; k++) begin
      for (int pos = 1; pos <= HW; pos++) begin
        if (covers(pos, k)) syn_o[k] = syn_o[k] ^ code_i[pos-1];
      end
    end
  end

  assign perr_o = ^code_i;

  for (genvar i = 0; i < DW; i++) begin : g_raw
    localparam int POS = data_pos(i);
    assign raw_o[i] = code_i[POS-1];
  end

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
#(
  parameter  int DW = 4,
  localparam int P  = chk_bits(DW),
  localparam int HW = DW + P
) (
  input  logic [DW-1:0] raw_i,
  input  logic [P-1:0]  syn_i,
  input  logic          perr_i,
  output logic [DW-1:0] data_o,
  output logic          corrected_o,
  output logic          uncorr_o
);

  logic in_range;
  logic nz;
  logic fix_en;

  // a complete code has no syndrome beyond its last position
  if (((1 << P) - 1) == HW) begin : g_full
    assign in_range = 1'b1;
  end else begin : g_part
    assign in_range = (syn_i <= P'(HW));
  end

  assign nz          = |syn_i;
  assign fix_en      = perr_i & nz & in_range;
  assign corrected_o = perr_i & in_range;
  assign uncorr_o    = (~perr_i & nz) | (perr_i & ~in_range);

  for (genvar i = 0; i < DW; i++) begin : g_fix
    localparam int POS = data_pos(i);
    assign data_o[i] = raw_i[i] ^ (fix_en & (syn_i == P'(POS)));
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter  int DW = 4,
  localparam int P  = chk_bits(DW),
  localparam int CW = DW + P + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enc_valid_i,
  input  logic [DW-1:0] enc_data_i,
  output logic          enc_valid_o,
  output logic [CW-1:0] enc_code_o,
  input  logic          dec_valid_i,
  input  logic [CW-1:0] dec_code_i,
  output logic          dec_valid_o,
  output logic [DW-1:0] dec_data_o,
  output logic          dec_corrected_o,
  output logic          dec_uncorrectable_o
);

  logic [CW-1:0] enc_code;
  logic [P-1:0]  syn;
  logic          perr;
  logic [DW-1:0] raw;
  logic [DW-1:0] fixed;
  logic          corr;
  logic          uncorr;

  secded_encoder #(.DW(DW)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code)
  );

  secded_syndrome #(.DW(DW)) u_syn (
    .code_i (dec_code_i),
    .syn_o  (syn),
    .perr_o (perr),
    .raw_o  (raw)
  );

  secded_corrector #(.DW(DW)) u_cor (
    .raw_i       (raw),
    .syn_i       (syn),
    .perr_i      (perr),
    .data_o      (fixed),
    .corrected_o (corr),
    .uncorr_o    (uncorr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o         <= 1'b0;
      dec_data_o          <= '0;
      dec_corrected_o     <= 1'b0;
      dec_uncorrectable_o <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o          <= fixed;
        dec_corrected_o     <= corr;
        dec_uncorrectable_o <= uncorr;
      end
    end
  end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int DW = 4,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enc_valid_i,
  input logic          enc_valid_o,
  input logic [CW-1:0] enc_code_o,
  input logic          dec_valid_i,
  input logic [CW-1:0] dec_code_i,
  input logic          dec_valid_o,
  input logic [DW-1:0] dec_data_o,
  input logic          dec_corrected_o,
  input logic          dec_uncorrectable_o
);

  p_enc_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);

  p_enc_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> !enc_valid_o);

  p_enc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> $stable(enc_code_o));

  p_enc_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o |-> !(^enc_code_o));

  p_dec_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);

  p_dec_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_corrected_o)
                      && $stable(dec_uncorrectable_o)));

  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_corrected_o && dec_uncorrectable_o));

  p_even_no_fix_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !(^dec_code_i)) |=> !dec_corrected_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r10: assert (!enc_valid_o && !dec_valid_o && !dec_corrected_o
                           && !dec_uncorrectable_o);
    end
  end

endmodule

bind secded_codec secded_codec_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .enc_valid_i         (enc_valid_i),
  .enc_valid_o         (enc_valid_o),
  .enc_code_o          (enc_code_o),
  .dec_valid_i         (dec_valid_i),
  .dec_code_i          (dec_code_i),
  .dec_valid_o         (dec_valid_o),
  .dec_data_o          (dec_data_o),
  .dec_corrected_o     (dec_corrected_o),
  .dec_uncorrectable_o (dec_uncorrectable_o)
);

// File: tb/secded_codec_test.sv
`timescale 1ns/1ps
module secded_codec_test;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // DW=4 instance
  logic       e4_vi = 1'b0, e4_vo, d4_vi = 1'b0, d4_vo, d4_c, d4_u;
  logic [3:0] e4_d = '0, d4_d;
  logic [7:0] e4_code, d4_code = '0;

  // DW=8 instance
  logic        e8_vi = 1'b0, e8_vo, d8_vi = 1'b0, d8_vo, d8_c, d8_u;
  logic [7:0]  e8_d = '0, d8_d;
  logic [12:0] e8_code, d8_code = '0;

  secded_codec #(.DW(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_valid_i(e4_vi), .enc_data_i(e4_d), .enc_valid_o(e4_vo), .enc_code_o(e4_code),
    .dec_valid_i(d4_vi), .dec_code_i(d4_code), .dec_valid_o(d4_vo), .dec_data_o(d4_d),
    .dec_corrected_o(d4_c), .dec_uncorrectable_o(d4_u)
  );

  secded_codec #(.DW(8)) uut_w8 (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_valid_i(e8_vi), .enc_data_i(e8_d), .enc_valid_o(e8_vo), .enc_code_o(e8_code),
    .dec_valid_i(d8_vi), .dec_code_i(d8_code), .dec_valid_o(d8_vo), .dec_data_o(d8_d),
    .dec_corrected_o(d8_c), .dec_uncorrectable_o(d8_u)
  );

  typedef struct packed {
    logic       dec;
    logic [7:0] din;
    logic [7:0] exp;
    logic       corr;
    logic       unc;
  } vec_t;

  // encode rows: din=data, exp=code; decode rows: din=code, exp=data
  localparam vec_t TBL [14] = '{
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0},  // R2
    '{1'b0, 8'h01, 8'h87, 1'b0, 1'b0},  // R1 R2
    '{1'b0, 8'h0F, 8'hFF, 1'b0, 1'b0},  // R2
    '{1'b0, 8'h0A, 8'hD2, 1'b0, 1'b0},  // R2
    '{1'b0, 8'h05, 8'h2D, 1'b0, 1'b0},  // R2
    '{1'b0, 8'h08, 8'h4B, 1'b0, 1'b0},  // R1
    '{1'b1, 8'h00, 8'h00, 1'b0, 1'b0},  // R4
    '{1'b1, 8'h2D, 8'h05, 1'b0, 1'b0},  // R4
    '{1'b1, 8'h83, 8'h01, 1'b1, 1'b0},  // R5 flip pos 3
    '{1'b1, 8'h6D, 8'h05, 1'b1, 1'b0},  // R5 flip pos 7
    '{1'b1, 8'hFE, 8'h0F, 1'b1, 1'b0},  // R5 flip pos 1
    '{1'b1, 8'h52, 8'h0A, 1'b1, 1'b0},  // R6 overall bit
    '{1'b1, 8'hC6, 8'h09, 1'b0, 1'b1},  // R7 flips pos 3,5
    '{1'b1, 8'hD1, 8'h0A, 1'b0, 1'b1}   // R7 flips pos 1,2
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] ref_enc8(input logic [7:0] d);
    logic [12:0] c;
    int di;
    logic pb;
    c = '0;
    di = 0;
    for (int pos = 1; pos <= 12; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos-1] = d[di];
        di++;
      end
    end
    for (int k = 0; k < 4; k++) begin
      pb = 1'b0;
      for (int pos = 1; pos <= 12; pos++)
        if (((pos >> k) & 1) == 1 && pos != (1 << k)) pb = pb ^ c[pos-1];
      c[(1 << k) - 1] = pb;
    end
    c[12] = ^c[11:0];
    return c;
  endfunction

  function automatic logic [7:0] ref_raw8(input logic [12:0] c);
    return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
  endfunction

  task automatic enc4(input logic [3:0] d);
    @(negedge clk); e4_vi = 1'b1; e4_d = d;
    @(negedge clk); e4_vi = 1'b0;
  endtask

  task automatic dec4(input logic [7:0] c);
    @(negedge clk); d4_vi = 1'b1; d4_code = c;
    @(negedge clk); d4_vi = 1'b0;
  endtask

  task automatic enc8(input logic [7:0] d);
    @(negedge clk); e8_vi = 1'b1; e8_d = d;
    @(negedge clk); e8_vi = 1'b0;
  endtask

  task automatic dec8(input logic [12:0] c);
    @(negedge clk); d8_vi = 1'b1; d8_code = c;
    @(negedge clk); d8_vi = 1'b0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset enc4", {7'd0, e4_vo, e4_code}, 16'h0);
    check("R10 reset dec4", {9'd0, d4_vo, d4_c, d4_u, d4_d}, 16'h0);
    check("R10 reset enc8", {2'd0, e8_vo, e8_code}, 16'h0);
    check("R10 reset dec8", {5'd0, d8_vo, d8_c, d8_u, d8_d}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 14; i++) begin
      if (TBL[i].dec) begin
        dec4(TBL[i].din);
        check($sformatf("R4-R7 row %0d data", i), {8'd0, 4'd0, d4_d}, {8'd0, TBL[i].exp});
        check($sformatf("R5 R6 R7 row %0d flags", i), {14'd0, d4_c, d4_u},
              {14'd0, TBL[i].corr, TBL[i].unc});
      end else begin
        enc4(TBL[i].din[3:0]);
        check($sformatf("R2 row %0d code", i), {8'd0, e4_code}, {8'd0, TBL[i].exp});
      end
    end

    // R3 latency and hold
    enc4(4'h5);
    check("R3 enc valid one cycle", {15'd0, e4_vo}, 16'h1);
    @(negedge clk); e4_d = 4'hF;
    check("R3 enc valid drops", {15'd0, e4_vo}, 16'h0);
    @(negedge clk); @(negedge clk);
    check("R3 enc code held", {8'd0, e4_code}, 16'h002D);

    // R9 latency and hold
    dec4(8'h83);
    check("R9 dec valid one cycle", {15'd0, d4_vo}, 16'h1);
    @(negedge clk); d4_code = 8'hC6;
    check("R9 dec valid drops", {15'd0, d4_vo}, 16'h0);
    @(negedge clk); @(negedge clk);
    check("R9 dec outputs held", {10'd0, d4_c, d4_u, d4_d}, {10'd0, 2'b10, 4'h1});

    // DW=8: layout, single flips, clean words
    for (int d = 0; d < 256; d++) begin
      logic [12:0] c;
      c = ref_enc8(d[7:0]);
      enc8(d[7:0]);
      check($sformatf("R1 R2 w8 enc %0d", d), {3'd0, e8_code}, {3'd0, c});
      if (d % 16 == 0) begin
        dec8(c);
        check($sformatf("R4 w8 clean %0d", d), {6'd0, d8_c, d8_u, d8_d}, {6'd0, 2'b00, d[7:0]});
      end
      for (int b = 0; b < 13; b++) begin
        dec8(c ^ (13'd1 << b));
        check($sformatf("R5 R6 w8 d=%0d bit %0d", d, b), {6'd0, d8_c, d8_u, d8_d},
              {6'd0, 2'b10, d[7:0]});
      end
    end

    // DW=8: double flips
    for (int d = 0; d < 256; d += 17) begin
      logic [12:0] c;
      logic [12:0] bad;
      c = ref_enc8(d[7:0]);
      for (int a = 0; a < 13; a++) begin
        for (int b = a + 1; b < 13; b++) begin
          bad = c ^ (13'd1 << a) ^ (13'd1 << b);
          dec8(bad);
          check($sformatf("R7 w8 d=%0d bits %0d,%0d", d, a, b), {6'd0, d8_c, d8_u, d8_d},
                {6'd0, 2'b01, ref_raw8(bad)});
        end
      end
    end

    // DW=8: syndrome 13 and 14 with odd parity (positions 1,4,8 and 2,4,8)
    dec8(ref_enc8(8'hA5) ^ 13'h089);
    check("R8 w8 syndrome 13", {6'd0, d8_c, d8_u, d8_d}, {6'd0, 2'b01, 8'hA5});
    dec8(ref_enc8(8'h3C) ^ 13'h08A);
    check("R8 w8 syndrome 14", {6'd0, d8_c, d8_u, d8_d}, {6'd0, 2'b01, 8'h3C});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R9 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule